// File: doc/BRIEF.md
# Constant Off-Time Current Chopper

This block regulates the current in one motor winding by chopping the bridge that drives it. While the bridge is on, the block watches a one-bit over-reference flag from an external sense comparator. When that flag is valid and high, the block drops its bridge-on request for a programmed number of system-clock cycles. It then raises the request again and starts a new on interval. The gate stage downstream adds its own dead time to the off interval. That dead time and the analog comparator are outside this block.

Two rules shape each on interval. A leading-edge blanking window ignores the flag for a set number of cycles after every turn-on, so the recovery spike that follows switching cannot start a new off interval. A minimum on time is also enforced. A valid trip that arrives before that time has elapsed is remembered and takes effect once the time is reached. The three durations come from run-time inputs counted in clock cycles. A low level on the enable input drops the request in the same cycle and clears all timing state.

Top module: `chop_ctrl`

## Requirements
- R1: While rst_i is high, bridge_on_o is 0. After the first rising edge that sees rst_i low and en_i high, bridge_on_o is 1, and this starts a fresh on interval.
- R2: trip_i passes through a two-flop synchronizer. Assume a rise of trip_i is neither blanked nor held back by the minimum on time. Then bridge_on_o is first seen low after the third rising clock edge that follows the rise.
- R3: After an accepted trip, bridge_on_o stays low for exactly off_cycles_i cycles and then returns to 1. A value of 0 is treated as 1.
- R4: During the first blank_cycles_i cycles of each on interval, the synchronized flag is ignored and is not remembered. If the flag is high from turn-on onward and min_on_cycles_i is at most blank_cycles_i+1, the on interval lasts blank_cycles_i+1 cycles.
- R5: A valid trip seen before min_on_cycles_i on-cycles have elapsed is held back. The bridge then turns off after exactly min_on_cycles_i on-cycles, even if the flag has fallen by then.
- R6: A flag pulse that occurs only while bridge_on_o is low does not change the length of the off interval. It does not cause a later turn-off either.
- R7: When en_i is low, bridge_on_o is 0 in that same cycle, and the timers and any held-back trip are cleared. After en_i returns high, the request rises at the next rising edge, and the new on interval has its full blanking window.
- R8: The off length is sampled when the turn-off is decided. The blanking and minimum-on values are sampled at that same point, and also while rst_i is high or en_i is low. A change in any of these values made in the middle of an interval therefore only applies from the next off event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Enable. When low, it forces the request low and clears all timers |
| trip_i | input | 1 | Asynchronous over-reference flag from the sense comparator |
| off_cycles_i | input | 16 | Off interval length in clock cycles |
| blank_cycles_i | input | 16 | Blanking window length in clock cycles |
| min_on_cycles_i | input | 16 | Minimum on interval length in clock cycles |
| bridge_on_o | output | 1 | Bridge-on request to the gate logic |

## Verification
Some properties are checked on every cycle. The length of every enabled off interval is compared against the off value captured at its turn-off. Every turn-off must respect both the blanking window and the minimum on time in force. A low enable must hold the request low in the same cycle, and a re-enable must raise the request one edge later.

Other behaviour only the bench scenarios can show. These are the synchronizer latency, the fact that a blanked trip or a trip during the off interval leaves no trace, and the exact on length when a trip is held back. They also include the timing of a configuration change made mid-interval.

// File: rtl/chop_pkg.sv
package chop_pkg;

    // width of every cycle-count input and timer
    parameter int unsigned CHOP_CNT_W = 16;

    typedef logic [CHOP_CNT_W-1:0] chop_cnt_t;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_ON   = 2'd1,
        ST_OFF  = 2'd2
    } chop_state_e;

    // durations that govern the current on interval
    typedef struct packed {
        chop_cnt_t blank;
        chop_cnt_t min_on;
    } chop_cfg_t;

    function automatic chop_cnt_t sat_inc(input chop_cnt_t v);
        return (v == '1) ? v : v + 1'b1;
    endfunction

    // on-cycle index at which a turn-off may first be decided
    function automatic chop_cnt_t min_gate(input chop_cnt_t m);
        return (m == '0) ? '0 : m - 1'b1;
    endfunction

    // off length actually loaded; zero is promoted to one cycle
    function automatic chop_cnt_t off_load(input chop_cnt_t v);
        return (v == '0) ? chop_cnt_t'(1) : v;
    endfunction

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) pipe_q[g] <= 1'b0;
                    else       pipe_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) pipe_q[g] <= 1'b0;
                    else       pipe_q[g] <= pipe_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/chop_on_timer.sv
module chop_on_timer
    import chop_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      clr_i,
    output chop_cnt_t age_o
);
    chop_cnt_t age_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) age_q <= '0;
        else                age_q <= sat_inc(age_q);
    end

    assign age_o = age_q;
endmodule

// File: rtl/chop_off_timer.sv
module chop_off_timer
    import chop_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      clr_i,
    input  logic      load_i,
    input  chop_cnt_t load_val_i,
    input  logic      run_i,
    output logic      done_o
);
    chop_cnt_t left_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i)              left_q <= '0;
        else if (load_i)                 left_q <= load_val_i;
        else if (run_i && left_q != '0)  left_q <= left_q - 1'b1;
    end

    assign done_o = (left_q <= chop_cnt_t'(1));
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  en_i,
    input  logic                  trip_i,
    input  logic [CHOP_CNT_W-1:0] off_cycles_i,
    input  logic [CHOP_CNT_W-1:0] blank_cycles_i,
    input  logic [CHOP_CNT_W-1:0] min_on_cycles_i,
    output logic                  bridge_on_o
);
    chop_state_e state_q, state_d;
    chop_cfg_t   cfg_q;
    logic        held_q;
    logic        trip_s;
    chop_cnt_t   age;
    logic        off_done;
    logic        trip_ok, on_ready, go_off;

    chop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (trip_i),
        .q_o   (trip_s)
    );

    chop_on_timer u_on (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_i (state_q != ST_ON || !en_i),
        .age_o (age)
    );

    chop_off_timer u_off (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .clr_i      (!en_i),
        .load_i     (go_off),
        .load_val_i (off_load(off_cycles_i)),
        .run_i      (state_q == ST_OFF),
        .done_o     (off_done)
    );

    // flag counts only once the blanking window has passed
    assign trip_ok  = trip_s && (age >= cfg_q.blank);
    assign on_ready = (age >= min_gate(cfg_q.min_on));
    assign go_off   = en_i && (state_q == ST_ON) && on_ready && (trip_ok || held_q);

    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD: state_d = ST_ON;
                ST_ON:   state_d = go_off ? ST_OFF : ST_ON;
                ST_OFF:  state_d = off_done ? ST_ON : ST_OFF;
                default: state_d = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_HOLD;
        else       state_q <= state_d;
    end

    // trip seen after blanking but before the minimum on time
    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i || state_q != ST_ON || go_off) held_q <= 1'b0;
        else if (trip_ok)                                  held_q <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i || go_off) begin
            cfg_q.blank  <= blank_cycles_i;
            cfg_q.min_on <= min_on_cycles_i;
        end
    end

    assign bridge_on_o = en_i && (state_q == ST_ON);
endmodule

// File: rtl/chop_ctrl_chk.sv
module chop_ctrl_chk
    import chop_pkg::*;
(
    input logic                  clk_i,
    input logic                  rst_i,
    input logic                  en_i,
    input logic [CHOP_CNT_W-1:0] off_cycles_i,
    input logic [CHOP_CNT_W-1:0] blank_cycles_i,
    input logic [CHOP_CNT_W-1:0] min_on_cycles_i,
    input logic                  bridge_on_o
);
    logic      prev_en, prev_on, off_run;
    chop_cnt_t prev_off, prev_blank, prev_min;
    chop_cnt_t hi_cnt, lo_cnt, c_off, c_blank, c_min;
    logic      fall_now, rise_now;

    assign fall_now = en_i && prev_en && prev_on && !bridge_on_o;
    assign rise_now = en_i && prev_en && !prev_on && bridge_on_o && off_run;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_en <= 1'b0; prev_on <= 1'b0; off_run <= 1'b0;
            prev_off <= '0; prev_blank <= '0; prev_min <= '0;
            hi_cnt <= '0; lo_cnt <= '0; c_off <= '0;
        end else begin
            prev_en    <= en_i;
            prev_on    <= bridge_on_o;
            prev_off   <= off_cycles_i;
            prev_blank <= blank_cycles_i;
            prev_min   <= min_on_cycles_i;
            hi_cnt     <= bridge_on_o ? sat_inc(hi_cnt) : '0;
            lo_cnt     <= (en_i && !bridge_on_o) ? sat_inc(lo_cnt) : '0;
            if (fall_now) begin
                c_off   <= off_load(prev_off);
                off_run <= 1'b1;
            end else if (!en_i || bridge_on_o) begin
                off_run <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            c_blank <= blank_cycles_i;
            c_min   <= min_on_cycles_i;
        end else if (fall_now) begin
            c_blank <= prev_blank;
            c_min   <= prev_min;
        end
    end

    p_off_len_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_now |-> (lo_cnt == c_off));

    p_blank_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        fall_now |-> (hi_cnt > c_blank));

    p_min_on_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        fall_now |-> (hi_cnt >= c_min));

    p_disable_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |-> !bridge_on_o);

    p_reenable_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !prev_en) |=> (bridge_on_o || !en_i));
endmodule

bind chop_ctrl chop_ctrl_chk chk_i (
    .clk_i           (clk_i),
    .rst_i           (rst_i),
    .en_i            (en_i),
    .off_cycles_i    (off_cycles_i),
    .blank_cycles_i  (blank_cycles_i),
    .min_on_cycles_i (min_on_cycles_i),
    .bridge_on_o     (bridge_on_o)
);

// File: tb/chop_ctrl_tb_top.sv
`timescale 1ns/1ps
module chop_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b1;
    logic        trip = 1'b0;
    logic [15:0] off_c = 16'd10;
    logic [15:0] blank_c = 16'd2;
    logic [15:0] min_c = 16'd3;
    logic        bridge_on;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    chop_ctrl dut_i (
        .clk_i           (clk),
        .rst_i           (rst),
        .en_i            (en),
        .trip_i          (trip),
        .off_cycles_i    (off_c),
        .blank_cycles_i  (blank_c),
        .min_on_cycles_i (min_c),
        .bridge_on_o     (bridge_on)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000 && !done) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            finish_run();
        end
    end

    // reference model, advanced at every rising edge from the requirements
    int m_st = 0, m_age = 0, m_rem = 0, m_blank = 0, m_min = 0;
    bit m_pend = 0, m_s1 = 0, m_s2 = 0;
    always @(posedge clk) begin
        bit fl, ok;
        int gate;
        if (rst) begin
            m_st = 0; m_age = 0; m_rem = 0; m_pend = 0; m_s1 = 0; m_s2 = 0;
            m_blank = blank_c; m_min = min_c;
        end else begin
            fl = m_s2; m_s2 = m_s1; m_s1 = trip;
            if (!en) begin
                m_st = 0; m_age = 0; m_pend = 0; m_rem = 0;
                m_blank = blank_c; m_min = min_c;
            end else if (m_st == 0) begin
                m_st = 1; m_age = 0;
            end else if (m_st == 1) begin
                ok = fl && (m_age >= m_blank);
                gate = (m_min == 0) ? 0 : m_min - 1;
                if (m_age >= gate && (ok || m_pend)) begin
                    m_st = 2; m_rem = (off_c == 0) ? 1 : off_c; m_pend = 0;
                    m_blank = blank_c; m_min = min_c;
                end else begin
                    if (ok) m_pend = 1;
                    if (m_age < 65535) m_age++;
                end
            end else begin
                if (m_rem <= 1) begin m_st = 1; m_age = 0; end
                else m_rem--;
            end
        end
    end

    // per-cycle comparison and run-length monitor
    int low_run = 0, high_run = 0, last_low = 0, last_high = 0;
    always @(negedge clk) begin
        if (!rst)
            check(bridge_on === (en && m_st == 1), "model R2 R3 R4 R5 R6 R7 R8",
                  int'(bridge_on), int'(en && m_st == 1));
        if (!bridge_on) begin
            if (high_run != 0) last_high = high_run;
            high_run = 0; low_run++;
        end else begin
            if (low_run != 0) last_low = low_run;
            low_run = 0; high_run++;
        end
    end

    task automatic wait_level(input logic v);
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (bridge_on == v) break;
        end
        #1;
    endtask

    task automatic restart();
        @(posedge clk); #1 en = 1'b0;
        repeat (2) @(posedge clk);
        #1 en = 1'b1;
        wait_level(1'b1);
    endtask

    task automatic pulse3();
        @(posedge clk); #1 trip = 1'b1;
        repeat (3) @(posedge clk);
        #1 trip = 1'b0;
    endtask

    initial begin
        int n;
        bit stay;
        void'($urandom(32'd20240611));

        // R1 reset state and first on interval
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(bridge_on == 1'b0, "R1 low in reset", bridge_on, 0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(bridge_on == 1'b0, "R1 hold before first edge", bridge_on, 0);
        @(negedge clk);
        check(bridge_on == 1'b1, "R1 on after first edge", bridge_on, 1);

        // R3 off length, R5 minimum on length with a held flag
        trip = 1'b1;
        wait_level(1'b0); wait_level(1'b1);
        check(last_low == 10, "R3 off length", last_low, 10);
        wait_level(1'b0);
        check(last_high == 3, "R5 on length min 3", last_high, 3);

        // R8 change during the off interval applies next time
        @(posedge clk); #1 off_c = 16'd4;
        wait_level(1'b1);
        check(last_low == 10, "R8 current off unchanged", last_low, 10);
        wait_level(1'b0); wait_level(1'b1);
        check(last_low == 4, "R8 next off uses new value", last_low, 4);

        // R6 flag activity during the off interval
        trip = 1'b0; blank_c = 16'd0; min_c = 16'd1; off_c = 16'd10;
        restart();
        @(posedge clk); #1 trip = 1'b1;
        wait_level(1'b0);
        @(posedge clk); #1 trip = 1'b0;
        repeat (2) @(posedge clk);
        #1 trip = 1'b1;
        @(posedge clk); #1 trip = 1'b0;
        wait_level(1'b1);
        check(last_low == 10, "R6 off length kept", last_low, 10);
        stay = 1;
        repeat (30) begin @(negedge clk); if (!bridge_on) stay = 0; end
        check(stay, "R6 no later trip", stay, 1);

        // R4 blanked pulse leaves no trace
        blank_c = 16'd8; min_c = 16'd1;
        restart();
        pulse3();
        stay = 1;
        repeat (40) begin @(negedge clk); if (!bridge_on) stay = 0; end
        check(stay, "R4 blanked pulse ignored", stay, 1);

        // R5 early trip held until the minimum on time
        blank_c = 16'd1; min_c = 16'd12;
        restart();
        pulse3();
        wait_level(1'b0);
        check(last_high == 12, "R5 deferred trip on length", last_high, 12);
        wait_level(1'b1);

        // R2 synchronizer latency
        blank_c = 16'd0; min_c = 16'd1;
        restart();
        repeat (5) @(posedge clk);
        #1 trip = 1'b1;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (!bridge_on) break;
        end
        check(n == 3, "R2 trip latency", n, 3);
        trip = 1'b0;
        wait_level(1'b1);

        // R7 immediate disable, fresh blanking on re-enable
        repeat (3) @(posedge clk);
        #1 en = 1'b0;
        #1 check(bridge_on == 1'b0, "R7 same-cycle disable", bridge_on, 0);
        blank_c = 16'd5; min_c = 16'd1; trip = 1'b1;
        repeat (3) @(posedge clk);
        #1 en = 1'b1;
        wait_level(1'b1);
        wait_level(1'b0);
        check(last_high == 6, "R7 R4 fresh blank after enable", last_high, 6);
        trip = 1'b0;

        // constrained random phase checked by the model
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #1;
            if ($urandom_range(0, 99) < 12) trip = ~trip;
            en = ($urandom_range(0, 99) < 97);
            if ($urandom_range(0, 99) < 3) begin
                off_c   = 16'($urandom_range(0, 15));
                blank_c = 16'($urandom_range(0, 10));
                min_c   = 16'($urandom_range(0, 15));
            end
        end
        en = 1'b1; trip = 1'b0;
        repeat (5) @(posedge clk);
        done = 1;
        finish_run();
    end
endmodule